// File: doc/BRIEF.md
# Stereo Soft Mute Ramp Controller

This block sits between a stereo PCM source and the converter core. It multiplies every left and right sample by a gain taken from a table of 1 dB steps. When the mute request goes low, the gain steps down by one entry per sample until it reaches silence. When the request goes high, the gain steps back up the same way. A full ramp in either direction takes 104 sample strobes. It also drives an analog-mute output, which is raised once the ramp has reached silence. The output is dropped before an un-mute ramp starts.

A clock-fault input forces the same two-stage sequence as a mute request. While the fault is present, the block stops taking new input. It scales the last sample accepted before the fault, ramps it down to silence, and then raises analog mute. A separate zero-data detector counts consecutive frames in which both channels are zero. When enabled, it raises analog mute after a threshold number of such frames. The first nonzero frame clears the count.

The ramp sequencer has four states:
- `ST_MUTED`: silent, analog mute high.
- `ST_UNMUTE`: gain rising.
- `ST_PLAY`: unity gain.
- `ST_ATTEN`: gain falling.

Its transitions are:
- `ST_MUTED` to `ST_UNMUTE` on a play request.
- `ST_UNMUTE` to `ST_PLAY` when the index reaches 0.
- `ST_PLAY` or `ST_UNMUTE` to `ST_ATTEN` when play is withdrawn.
- `ST_ATTEN` to `ST_UNMUTE` when play returns.
- `ST_ATTEN` to `ST_MUTED` when the index reaches 104.

Top module: `smute_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it: `amute` is 1, `ramp_busy` is 0, `out_vld` is 0, and both outputs are 0. The gain index starts at 104 (silent).
- R2: Gain entry k is round(32768 * 10^(-k/20)) for k in 0..103, and entry 104 is exactly 0. Each strobe produces one output pair, with `out_vld` high for one cycle in the cycle after the strobe. Each output is floor((s*g + 16384) / 32768), using the gain index held before that strobe.
- R3: When play is withdrawn (`play_en` low or `clk_fault` high), the index rises by one per strobe. From unity, silence is reached after 104 strobes. `ramp_busy` is high during the ramp. `amute` rises in the cycle after the strobe that reaches index 104, and the outputs stay 0 after that.
- R4: When play is requested in the muted state, `amute` falls and `ramp_busy` rises one cycle later, before any strobe. The index then falls by one per strobe, reaching unity (index 0) after 104 strobes. At that point `ramp_busy` falls.
- R5: A request that reverses during a ramp continues from the current index in the new direction, without a jump.
- R6: In cycles without a strobe, the gain index does not change.
- R7: With `zd_en` high and no fault, `amute` rises after 1024 consecutive strobes in which both samples are zero. A strobe with either sample nonzero clears the count, and `amute` falls in the next cycle.
- R8: With `zd_en` low, zero-valued frames never raise `amute`.
- R9: While `clk_fault` is high, each strobe scales the last pair accepted before the fault, and the gain ramps down to silence followed by analog mute. When the fault clears with play requested, live data ramps back up.
- R10: At index 0 the output equals the input exactly, including at both full-scale extremes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | One-cycle strobe marking a new sample pair |
| smp_l | input | 24 | Left sample, two's complement |
| smp_r | input | 24 | Right sample, two's complement |
| play_en | input | 1 | 1 requests playback, 0 requests mute |
| clk_fault | input | 1 | Clock or supply fault; forces mute and holds data |
| zd_en | input | 1 | Enables the zero-data analog mute |
| out_l | output | 24 | Scaled left sample |
| out_r | output | 24 | Scaled right sample |
| out_vld | output | 1 | Output pair valid for one cycle |
| amute | output | 1 | Analog mute request |
| ramp_busy | output | 1 | Gain ramp in progress |

## Verification
The assertions watch on every cycle that the gain index moves by at most one step per strobe and stays still without one. They also check that a play request in the muted state drops analog mute in the next cycle, that a silent state yields zero output, that unity gain passes data unchanged, and that a nonzero frame clears the zero counter. The exact coefficient values, the rounding, and the 104-strobe ramp length can only be shown by the bench's scenarios. The same is true of mid-ramp reversal, fault-time holding of the last good pair, and the 1024-frame zero threshold: the bench compares every output pair against a scoreboard computed from the requirements.

// File: rtl/smute_pkg.sv
package smute_pkg;

    typedef enum logic [1:0] {
        ST_MUTED  = 2'd0,
        ST_UNMUTE = 2'd1,
        ST_PLAY   = 2'd2,
        ST_ATTEN  = 2'd3
    } ramp_st_t;

    // Linear coefficient for a k dB cut, scaled by 2^frac; zero at and beyond the last step.
    function automatic int unsigned gain_coef(input int k, input int steps, input int frac);
        real lin;
        if (k >= steps) return 0;
        lin = (2.0 ** frac) * (10.0 ** (-real'(k) / 20.0));
        return $rtoi(lin + 0.5);
    endfunction

endpackage

// File: rtl/smute_gain_rom.sv
module smute_gain_rom #(
    parameter int STEPS = 104,
    parameter int GW    = 17,
    parameter int FRAC  = 15,
    parameter int IW    = $clog2(STEPS + 1)
) (
    input  logic [IW-1:0] idx,
    output logic [GW-1:0] gain
);
    localparam int ENTRIES = 1 << IW;

    logic [GW-1:0] tbl [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        localparam logic [GW-1:0] COEF = GW'(smute_pkg::gain_coef(i, STEPS, FRAC));
        assign tbl[i] = COEF;
    end

    assign gain = tbl[idx];

endmodule

// File: rtl/smute_scaler.sv
module smute_scaler #(
    parameter int DW   = 24,
    parameter int GW   = 17,
    parameter int FRAC = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [DW-1:0] din,
    input  logic [GW-1:0] gain,
    output logic [DW-1:0] dout
);
    localparam int PW = DW + GW + 1;
    localparam logic signed [PW-1:0] MAXV = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [PW-1:0] MINV = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};
    localparam logic signed [PW-1:0] HALF = PW'(1) << (FRAC - 1);

    logic signed [PW-1:0] a_ext;
    logic signed [PW-1:0] g_ext;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] shifted;
    logic        [DW-1:0] clipped;

    assign a_ext   = {{(PW-DW){din[DW-1]}}, din};
    assign g_ext   = {{(PW-GW){1'b0}}, gain};
    assign prod    = a_ext * g_ext;
    assign shifted = (prod + HALF) >>> FRAC;

    always_comb begin
        if (shifted > MAXV)      clipped = MAXV[DW-1:0];
        else if (shifted < MINV) clipped = MINV[DW-1:0];
        else                     clipped = shifted[DW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  dout <= '0;
        else if (en) dout <= clipped;
    end

endmodule

// File: rtl/smute_zero_det.sv
module smute_zero_det #(
    parameter int DW    = 24,
    parameter int LIMIT = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb,
    input  logic          frz,
    input  logic          en,
    input  logic [DW-1:0] sl,
    input  logic [DW-1:0] sr,
    output logic          hit
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;
    logic          both_zero;

    assign both_zero = (sl == '0) && (sr == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (stb && !frz) begin
            if (!both_zero)                cnt <= '0;
            else if (cnt != CW'(LIMIT))    cnt <= cnt + 1'b1;
        end
    end

    assign hit = en && (cnt == CW'(LIMIT));

    AST_ZERO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !frz && !both_zero) |=> (cnt == '0)); // R7

endmodule

// File: rtl/smute_seq.sv
module smute_seq #(
    parameter int STEPS = 104,
    parameter int IW    = $clog2(STEPS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb,
    input  logic          want,
    output logic [IW-1:0] idx,
    output logic          silent,
    output logic          busy
);
    import smute_pkg::*;

    localparam logic [IW-1:0] TOP = IW'(STEPS);

    ramp_st_t      st, st_n;
    logic [IW-1:0] idx_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_MUTED;
            idx <= TOP;
        end else begin
            st  <= st_n;
            idx <= idx_n;
        end
    end

    always_comb begin
        st_n  = st;
        idx_n = idx;
        unique case (st)
            ST_MUTED: begin
                if (want) st_n = ST_UNMUTE;
            end
            ST_UNMUTE, ST_PLAY, ST_ATTEN: begin
                if (stb) begin
                    if (want && idx != '0)       idx_n = idx - 1'b1;
                    else if (!want && idx != TOP) idx_n = idx + 1'b1;
                end
                if (want) st_n = (idx_n == '0)  ? ST_PLAY  : ST_UNMUTE;
                else      st_n = (idx_n == TOP) ? ST_MUTED : ST_ATTEN;
            end
            default: st_n = ST_MUTED;
        endcase
    end

    always_comb begin
        silent = (st == ST_MUTED);
        busy   = (st == ST_UNMUTE) || (st == ST_ATTEN);
    end

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> ((idx == $past(idx)) || (idx == $past(idx) + 1'b1) || (idx + 1'b1 == $past(idx)))); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(idx)); // R6
    AST_UNMUTE_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_MUTED && want) |=> !silent); // R4

endmodule

// File: rtl/smute_ctrl.sv
module smute_ctrl #(
    parameter int DW         = 24,
    parameter int STEPS      = 104,
    parameter int FRAC       = 15,
    parameter int ZERO_LIMIT = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_stb,
    input  logic [DW-1:0] smp_l,
    input  logic [DW-1:0] smp_r,
    input  logic          play_en,
    input  logic          clk_fault,
    input  logic          zd_en,
    output logic [DW-1:0] out_l,
    output logic [DW-1:0] out_r,
    output logic          out_vld,
    output logic          amute,
    output logic          ramp_busy
);
    localparam int GW = FRAC + 2;
    localparam int IW = $clog2(STEPS + 1);

    logic [IW-1:0] gain_idx;
    logic [GW-1:0] gain;
    logic          ramp_silent;
    logic          zero_hit;
    logic          want;
    logic [DW-1:0] hold_l, hold_r;
    logic [DW-1:0] src  [2];
    logic [DW-1:0] res  [2];

    assign want = play_en && !clk_fault;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_l  <= '0;
            hold_r  <= '0;
            out_vld <= 1'b0;
        end else begin
            out_vld <= smp_stb;
            if (smp_stb && !clk_fault) begin
                hold_l <= smp_l;
                hold_r <= smp_r;
            end
        end
    end

    assign src[0] = clk_fault ? hold_l : smp_l;
    assign src[1] = clk_fault ? hold_r : smp_r;

    smute_seq #(.STEPS(STEPS), .IW(IW)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb    (smp_stb),
        .want   (want),
        .idx    (gain_idx),
        .silent (ramp_silent),
        .busy   (ramp_busy)
    );

    smute_gain_rom #(.STEPS(STEPS), .GW(GW), .FRAC(FRAC), .IW(IW)) u_rom (
        .idx  (gain_idx),
        .gain (gain)
    );

    for (genvar ch = 0; ch < 2; ch++) begin : g_ch
        smute_scaler #(.DW(DW), .GW(GW), .FRAC(FRAC)) u_scl (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (smp_stb),
            .din   (src[ch]),
            .gain  (gain),
            .dout  (res[ch])
        );
    end

    assign out_l = res[0];
    assign out_r = res[1];

    smute_zero_det #(.DW(DW), .LIMIT(ZERO_LIMIT)) u_zd (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (smp_stb),
        .frz   (clk_fault),
        .en    (zd_en),
        .sl    (smp_l),
        .sr    (smp_r),
        .hit   (zero_hit)
    );

    assign amute = ramp_silent || zero_hit;

    AST_SILENT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && ramp_silent) |=> (out_l == '0 && out_r == '0)); // R3
    AST_UNITY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && gain_idx == '0 && !clk_fault) |=> (out_l == $past(smp_l) && out_r == $past(smp_r))); // R10

endmodule

// File: tb/sim_smute_ctrl.sv
module sim_smute_ctrl;
    localparam int DW = 24;
    localparam int STEPS = 104;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_stb = 1'b0;
    logic [DW-1:0] smp_l = '0, smp_r = '0;
    logic play_en = 1'b0, clk_fault = 1'b0, zd_en = 1'b0;
    logic [DW-1:0] out_l, out_r;
    logic out_vld, amute, ramp_busy;

    int checks = 0;
    int errors = 0;

    logic [2*DW-1:0] exp_q [$];
    string           tag_q [$];

    int              idx_m = STEPS;
    logic [DW-1:0]   held_l = '0, held_r = '0;

    always #2.5 clk = ~clk;

    smute_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_l(smp_l), .smp_r(smp_r),
        .play_en(play_en), .clk_fault(clk_fault), .zd_en(zd_en),
        .out_l(out_l), .out_r(out_r), .out_vld(out_vld), .amute(amute), .ramp_busy(ramp_busy)
    );

    function automatic logic [DW-1:0] expect_scaled(input logic [DW-1:0] s, input int k);
        longint g, p;
        if (k >= STEPS) g = 0;
        else g = longint'($rtoi(32768.0 * $pow(10.0, -real'(k) / 20.0) + 0.5));
        p = (longint'($signed(s)) * g + 64'sd16384) >>> 15;
        if (p > 64'sd8388607) p = 64'sd8388607;
        if (p < -64'sd8388608) p = -64'sd8388608;
        return p[DW-1:0];
    endfunction

    function automatic logic [DW-1:0] pat(input int k, input int salt);
        return DW'((k * 1234567 + salt * 7654321) ^ (k << 13));
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic send(input logic [DW-1:0] l, input logic [DW-1:0] r, input string tag);
        logic [DW-1:0] dl, dr;
        dl = clk_fault ? held_l : l;
        dr = clk_fault ? held_r : r;
        exp_q.push_back({expect_scaled(dl, idx_m), expect_scaled(dr, idx_m)});
        tag_q.push_back(tag);
        if (!clk_fault) begin held_l = l; held_r = r; end
        if (play_en && !clk_fault) begin if (idx_m > 0) idx_m--; end
        else begin if (idx_m < STEPS) idx_m++; end
        smp_l = l; smp_r = r; smp_stb = 1'b1;
        @(negedge clk);
        smp_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_ctrl(input logic p, input logic f);
        play_en = p; clk_fault = f;
        @(negedge clk);
        @(negedge clk);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_vld) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R2: unexpected output actual=%0h/%0h expected=none", out_l, out_r);
            end else begin
                logic [2*DW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({t, " left"}, out_l, e[2*DW-1:DW]);
                chk({t, " right"}, out_r, e[DW-1:0]);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        chk("R1 amute in reset", DW'(amute), DW'(1));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 amute", DW'(amute), DW'(1));
        chk("R1 busy", DW'(ramp_busy), DW'(0));
        chk("R1 out_vld", DW'(out_vld), DW'(0));
        chk("R1 out_l", out_l, '0);

        // R4 un-mute: analog mute drops before any sample
        play_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R4 amute released", DW'(amute), DW'(0));
        chk("R4 busy", DW'(ramp_busy), DW'(1));
        for (int k = 0; k < 10; k++) send(pat(k, 1), pat(k, 2), "R4");
        repeat (30) @(negedge clk);                 // R6 no strobes: index must hold
        for (int k = 10; k < STEPS; k++) send(pat(k, 3), (k % 2 == 0) ? 24'h800000 : 24'h7fffff, "R6");
        chk("R4 busy end", DW'(ramp_busy), DW'(0));

        // R10 unity
        send(24'h7fffff, 24'h800000, "R10");
        send(24'h000001, 24'hffffff, "R10");
        for (int k = 0; k < 6; k++) send(pat(k, 9), pat(k, 11), "R10");

        // R3 partial mute then R5 reversal
        set_ctrl(1'b0, 1'b0);
        for (int k = 0; k < 40; k++) send(pat(k, 5), pat(k, 6), "R3");
        chk("R3 busy", DW'(ramp_busy), DW'(1));
        set_ctrl(1'b1, 1'b0);
        for (int k = 0; k < 40; k++) send(pat(k, 7), pat(k, 8), "R5");
        chk("R5 busy end", DW'(ramp_busy), DW'(0));

        // R3 full mute
        set_ctrl(1'b0, 1'b0);
        for (int k = 0; k < STEPS; k++) send(24'h7fffff - DW'(k), 24'h800000 + DW'(k), "R3");
        chk("R3 amute", DW'(amute), DW'(1));
        chk("R3 busy", DW'(ramp_busy), DW'(0));
        for (int k = 0; k < 4; k++) send(pat(k, 12), pat(k, 13), "R3");

        // back to play
        set_ctrl(1'b1, 1'b0);
        for (int k = 0; k < STEPS; k++) send(pat(k, 14), pat(k, 15), "R2");

        // R9 fault: hold last good pair, ramp down, then analog mute
        send(24'h123456, 24'hedcba9, "R9");
        set_ctrl(1'b1, 1'b1);
        for (int k = 0; k < STEPS; k++) send(pat(k, 16), pat(k, 17), "R9");
        chk("R9 amute", DW'(amute), DW'(1));
        set_ctrl(1'b1, 1'b0);
        chk("R9 amute release", DW'(amute), DW'(0));
        for (int k = 0; k < STEPS; k++) send(pat(k, 18), pat(k, 19), "R9");

        // R7 zero detect
        zd_en = 1'b1;
        for (int k = 0; k < 1023; k++) send('0, '0, "R7");
        chk("R7 amute before limit", DW'(amute), DW'(0));
        send('0, '0, "R7");
        chk("R7 amute at limit", DW'(amute), DW'(1));
        send('0, 24'h000010, "R7");
        chk("R7 amute cleared", DW'(amute), DW'(0));
        for (int k = 0; k < 1000; k++) send('0, '0, "R7");
        send(24'h000003, '0, "R7");
        for (int k = 0; k < 1000; k++) send('0, '0, "R7");
        chk("R7 count restarted", DW'(amute), DW'(0));

        // R8 disabled detector
        zd_en = 1'b0;
        for (int k = 0; k < 1030; k++) send('0, '0, "R8");
        chk("R8 amute", DW'(amute), DW'(0));

        repeat (4) @(negedge clk);
        chk("R2 queue drained", DW'(exp_q.size()), '0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule